// File: doc/BRIEF.md
# Ordered Store Queue with Load Forwarding

This block holds stores after they execute and until they are written into the local data cache. A slot is taken at the tail for each store in program order. The execution stage fills the slot with a byte address and a data byte. A separate retirement signal then marks the oldest speculative slot as final. The queue writes to the cache only from its oldest end. A write goes out only when the head slot is final and its cache line is held with write permission. Several slots in a row at the head that target the same line leave together as one line write with byte enables.

Write permission for a line is requested through an ownership port. Requests are raised for any filled slot, including slots far from the head, so several line fetches can be outstanding at once. Loads look up the queue combinationally. A one-byte load takes its data from the youngest older store to the same byte. A line-wide load, or any load behind a store whose address is still unknown, is told to wait. A flush from a mispredicted branch drops every speculative slot in one cycle. Final slots survive the flush and still drain.

Each slot runs a small state machine. SLOT_FREE goes to SLOT_WAIT on allocation. SLOT_WAIT goes to SLOT_SPEC on execute, or back to SLOT_FREE on flush. SLOT_SPEC goes to SLOT_DONE on retire, or to SLOT_FREE on flush; retire wins when both arrive together. SLOT_DONE goes to SLOT_FREE when it drains to the cache. DEPTH must be a power of two, at least 2.

Top module: `store_queue`

## Requirements
- R1: Slots are written to the cache strictly oldest first. A younger slot whose line is owned never leaves while an older slot is still held.
- R2: A slot is written to the cache only after it has been executed and then retired. A slot that is filled and owned but not retired keeps commit_valid_o low.
- R3: A slot is written to the cache only after a grant (gnt_i with gnt_line_i equal to its line, line = address >> 2) has arrived after the slot was filled. commit_valid_o shows the write in the cycle after the grant edge.
- R4: Consecutive retired, owned slots at the head on the same line leave in one cycle. commit_be_o bit k marks byte lane k = address[1:0], and lane k data sits at commit_data_o[8k+7:8k]. Where two slots share a lane, the younger slot's byte wins.
- R5: rfo_valid_o/rfo_line_o requests the line of the oldest filled slot that is neither owned nor already requested. Slots behind the head are served, and one request marks every filled slot of that line as requested.
- R6: A byte load (ld_wide_i=0) returns ld_hit_o=1 with the data of the youngest store older than the load at the same byte address. Older stores are the slots from the head up to ld_tail_i, a pointer in the same encoding as alloc_ptr_o. With no match, both ld_hit_o and ld_wait_o are 0.
- R7: ld_wait_o=1 and ld_hit_o=0 when any older slot has no address yet, or when a line-wide load (ld_wide_i=1) shares its line with any older store.
- R8: flush_i frees every non-retired slot in one cycle and sets the tail to just past the youngest retired slot. Retired slots stay and later drain.
- R9: full_o is 1 when DEPTH slots are in use, and alloc_i is then ignored. drained_o is 1 when no slot is in use. alloc_ptr_o is the tail pointer, of width log2(DEPTH)+1, with a wrap bit on top.
- R10: After reset the queue is empty: drained_o=1, full_o=0, alloc_ptr_o=0, commit_valid_o=0, rfo_valid_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| alloc_i | input | 1 | Allocate one slot at the tail |
| alloc_ptr_o | output | PW+1 | Tail pointer with wrap bit; slot index is the low bits |
| full_o | output | 1 | All slots in use |
| drained_o | output | 1 | No slot in use |
| exec_i | input | 1 | Fill a slot with address and data |
| exec_idx_i | input | PW | Slot index to fill |
| exec_addr_i | input | AW | Byte address of the store |
| exec_data_i | input | 8 | Store data byte |
| retire_i | input | 1 | Mark the oldest speculative slot retired |
| flush_i | input | 1 | Drop all speculative slots |
| rfo_valid_o | output | 1 | Ownership request valid |
| rfo_line_o | output | AW-2 | Requested line address |
| gnt_i | input | 1 | Ownership grant |
| gnt_line_i | input | AW-2 | Granted line address |
| commit_valid_o | output | 1 | Line write to the cache this cycle |
| commit_line_o | output | AW-2 | Line written |
| commit_be_o | output | LINE_BYTES | Byte enables per lane |
| commit_data_o | output | 8*LINE_BYTES | Merged line data |
| ld_addr_i | input | AW | Load byte address |
| ld_wide_i | input | 1 | Load covers the whole line |
| ld_tail_i | input | PW+1 | Tail pointer seen by the load at dispatch |
| ld_hit_o | output | 1 | Forwarded data valid |
| ld_wait_o | output | 1 | Load must retry later |
| ld_data_o | output | 8 | Forwarded byte |

## Verification
The assertions assume well-formed input. retire_i arrives only when the oldest non-retired slot has executed. exec_i names only a slot in SLOT_WAIT. ld_tail_i lies between the head and tail pointers. The stimulus keeps to all three: it fills only slots it has just allocated, retires in the order it executed, and builds every load pointer from the allocation pointers it observed. Grants are given only for lines the queue has requested.

// File: rtl/sq_pkg.sv
package sq_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_SPEC = 2'd2,
        SLOT_DONE = 2'd3
    } slot_state_e;
endpackage

// File: rtl/sq_slot.sv
module sq_slot
    import sq_pkg::*;
#(
    parameter int AW  = 12,
    parameter int LBW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic              fill_i,
    input  logic [AW-1:0]     fill_addr_i,
    input  logic [7:0]        fill_data_i,
    input  logic              retire_i,
    input  logic              flush_i,
    input  logic              drain_i,
    input  logic              mark_i,
    input  logic              gnt_i,
    input  logic [AW-LBW-1:0] gnt_line_i,
    output slot_state_e       state_o,
    output logic [AW-1:0]     addr_o,
    output logic [7:0]        data_o,
    output logic              asked_o,
    output logic              owned_o
);
    slot_state_e state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;
    logic          asked_q, owned_q;
    logic          filled;

    assign filled = (state_q == SLOT_SPEC) || (state_q == SLOT_DONE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: if (alloc_i) state_d = SLOT_WAIT;
            SLOT_WAIT: begin
                if (flush_i)     state_d = SLOT_FREE;
                else if (fill_i) state_d = SLOT_SPEC;
            end
            SLOT_SPEC: begin
                if (retire_i)     state_d = SLOT_DONE;
                else if (flush_i) state_d = SLOT_FREE;
            end
            SLOT_DONE: if (drain_i) state_d = SLOT_FREE;
            default:   state_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            data_q  <= '0;
            asked_q <= 1'b0;
            owned_q <= 1'b0;
        end else begin
            if (state_q == SLOT_WAIT && fill_i && !flush_i) begin
                addr_q <= fill_addr_i;
                data_q <= fill_data_i;
            end
            if (state_q == SLOT_FREE && alloc_i) begin
                asked_q <= 1'b0;
                owned_q <= 1'b0;
            end else begin
                if (mark_i) asked_q <= 1'b1;
                if (gnt_i && filled && addr_q[AW-1:LBW] == gnt_line_i) owned_q <= 1'b1;
            end
        end
    end

    assign state_o = state_q;
    assign addr_o  = addr_q;
    assign data_o  = data_q;
    assign asked_o = asked_q;
    assign owned_o = owned_q;

    // A retired slot is untouched by a flush unless it drains.
    assert_flush_keeps_retired_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_DONE && flush_i && !drain_i) |=> state_q == SLOT_DONE);

    // Execute only targets a slot waiting for its data.
    assert_fill_allocated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_i |-> state_q == SLOT_WAIT);
endmodule

// File: rtl/sq_rfo_pick.sv
module sq_rfo_pick
    import sq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 12,
    parameter int LBW   = 2,
    localparam int PW   = $clog2(DEPTH),
    localparam int LW   = AW - LBW
) (
    input  slot_state_e      st_i    [DEPTH],
    input  logic [AW-1:0]    addr_i  [DEPTH],
    input  logic [DEPTH-1:0] asked_i,
    input  logic [DEPTH-1:0] owned_i,
    input  logic [PW-1:0]    head_i,
    output logic             req_valid_o,
    output logic [LW-1:0]    req_line_o,
    output logic [DEPTH-1:0] mark_o
);
    logic found;

    always_comb begin
        found      = 1'b0;
        req_line_o = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (!found
                && (st_i[head_i + PW'(k)] == SLOT_SPEC || st_i[head_i + PW'(k)] == SLOT_DONE)
                && !asked_i[head_i + PW'(k)] && !owned_i[head_i + PW'(k)]) begin
                found      = 1'b1;
                req_line_o = addr_i[head_i + PW'(k)][AW-1:LBW];
            end
        end
        req_valid_o = found;
        for (int i = 0; i < DEPTH; i++) begin
            mark_o[i] = found && !owned_i[i]
                && (st_i[i] == SLOT_SPEC || st_i[i] == SLOT_DONE)
                && addr_i[i][AW-1:LBW] == req_line_o;
        end
    end
endmodule

// File: rtl/sq_commit.sv
module sq_commit
    import sq_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int AW         = 12,
    parameter int LINE_BYTES = 4,
    localparam int PW        = $clog2(DEPTH),
    localparam int LBW       = $clog2(LINE_BYTES),
    localparam int LW        = AW - LBW
) (
    input  slot_state_e             st_i    [DEPTH],
    input  logic [AW-1:0]           addr_i  [DEPTH],
    input  logic [7:0]              data_i  [DEPTH],
    input  logic [DEPTH-1:0]        owned_i,
    input  logic [PW-1:0]           head_i,
    input  logic [PW:0]             used_i,
    output logic                    valid_o,
    output logic [LW-1:0]           line_o,
    output logic [LINE_BYTES-1:0]   be_o,
    output logic [8*LINE_BYTES-1:0] data_o,
    output logic [PW:0]             take_o,
    output logic [DEPTH-1:0]        drain_o
);
    logic          run;
    logic [PW-1:0] idx;

    always_comb begin
        run     = 1'b1;
        idx     = head_i;
        take_o  = '0;
        be_o    = '0;
        data_o  = '0;
        drain_o = '0;
        line_o  = addr_i[head_i][AW-1:LBW];
        for (int k = 0; k < DEPTH; k++) begin
            idx = head_i + PW'(k);
            if (run && (PW+1)'(k) < used_i && st_i[idx] == SLOT_DONE && owned_i[idx]
                && addr_i[idx][AW-1:LBW] == line_o) begin
                take_o       = take_o + 1'b1;
                drain_o[idx] = 1'b1;
                be_o[addr_i[idx][LBW-1:0]] = 1'b1;
                data_o[8*int'(addr_i[idx][LBW-1:0]) +: 8] = data_i[idx];
            end else begin
                run = 1'b0;
            end
        end
        valid_o = (take_o != '0);
    end
endmodule

// File: rtl/sq_fwd.sv
module sq_fwd
    import sq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 12,
    parameter int LBW   = 2,
    localparam int PW   = $clog2(DEPTH)
) (
    input  slot_state_e   st_i   [DEPTH],
    input  logic [AW-1:0] addr_i [DEPTH],
    input  logic [7:0]    data_i [DEPTH],
    input  logic [PW:0]   head_i,
    input  logic [AW-1:0] ld_addr_i,
    input  logic          ld_wide_i,
    input  logic [PW:0]   ld_tail_i,
    output logic          hit_o,
    output logic          wait_o,
    output logic [7:0]    data_o
);
    logic [PW:0]   older;
    logic [PW-1:0] idx;
    logic          match, pend;
    logic [7:0]    val;

    always_comb begin
        older = ld_tail_i - head_i;
        idx   = head_i[PW-1:0];
        match = 1'b0;
        pend  = 1'b0;
        val   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head_i[PW-1:0] + PW'(k);
            if ((PW+1)'(k) < older) begin
                if (st_i[idx] == SLOT_WAIT) begin
                    pend = 1'b1;
                end else if (st_i[idx] == SLOT_SPEC || st_i[idx] == SLOT_DONE) begin
                    if (ld_wide_i) begin
                        if (addr_i[idx][AW-1:LBW] == ld_addr_i[AW-1:LBW]) pend = 1'b1;
                    end else if (addr_i[idx] == ld_addr_i) begin
                        match = 1'b1;
                        val   = data_i[idx];
                    end
                end
            end
        end
        wait_o = pend;
        hit_o  = match && !pend;
        data_o = hit_o ? val : 8'h00;
    end
endmodule

// File: rtl/store_queue.sv
module store_queue
    import sq_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int AW         = 12,
    parameter int LINE_BYTES = 4,
    localparam int PW        = $clog2(DEPTH),
    localparam int LBW       = $clog2(LINE_BYTES),
    localparam int LW        = AW - LBW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_i,
    output logic [PW:0]             alloc_ptr_o,
    output logic                    full_o,
    output logic                    drained_o,
    input  logic                    exec_i,
    input  logic [PW-1:0]           exec_idx_i,
    input  logic [AW-1:0]           exec_addr_i,
    input  logic [7:0]              exec_data_i,
    input  logic                    retire_i,
    input  logic                    flush_i,
    output logic                    rfo_valid_o,
    output logic [LW-1:0]           rfo_line_o,
    input  logic                    gnt_i,
    input  logic [LW-1:0]           gnt_line_i,
    output logic                    commit_valid_o,
    output logic [LW-1:0]           commit_line_o,
    output logic [LINE_BYTES-1:0]   commit_be_o,
    output logic [8*LINE_BYTES-1:0] commit_data_o,
    input  logic [AW-1:0]           ld_addr_i,
    input  logic                    ld_wide_i,
    input  logic [PW:0]             ld_tail_i,
    output logic                    ld_hit_o,
    output logic                    ld_wait_o,
    output logic [7:0]              ld_data_o
);
    logic [PW:0] head_q, tail_q, ret_q, used, take, ret_next;
    logic        alloc_fire;

    slot_state_e      st     [DEPTH];
    logic [AW-1:0]    s_addr [DEPTH];
    logic [7:0]       s_data [DEPTH];
    logic [DEPTH-1:0] s_asked, s_owned, s_mark, s_drain;

    assign used        = tail_q - head_q;
    assign full_o      = (used == (PW+1)'(DEPTH));
    assign drained_o   = (used == '0);
    assign alloc_ptr_o = tail_q;
    assign alloc_fire  = alloc_i && !full_o && !flush_i;
    assign ret_next    = ret_q + (PW+1)'(retire_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            ret_q  <= '0;
        end else begin
            head_q <= head_q + take;
            ret_q  <= ret_next;
            if (flush_i) tail_q <= ret_next;
            else         tail_q <= tail_q + (PW+1)'(alloc_fire);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        sq_slot #(.AW(AW), .LBW(LBW)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_i    (alloc_fire && tail_q[PW-1:0] == PW'(g)),
            .fill_i     (exec_i && exec_idx_i == PW'(g)),
            .fill_addr_i(exec_addr_i),
            .fill_data_i(exec_data_i),
            .retire_i   (retire_i && ret_q[PW-1:0] == PW'(g)),
            .flush_i    (flush_i),
            .drain_i    (s_drain[g]),
            .mark_i     (s_mark[g]),
            .gnt_i      (gnt_i),
            .gnt_line_i (gnt_line_i),
            .state_o    (st[g]),
            .addr_o     (s_addr[g]),
            .data_o     (s_data[g]),
            .asked_o    (s_asked[g]),
            .owned_o    (s_owned[g])
        );
    end

    sq_rfo_pick #(.DEPTH(DEPTH), .AW(AW), .LBW(LBW)) u_pick (
        .st_i       (st),
        .addr_i     (s_addr),
        .asked_i    (s_asked),
        .owned_i    (s_owned),
        .head_i     (head_q[PW-1:0]),
        .req_valid_o(rfo_valid_o),
        .req_line_o (rfo_line_o),
        .mark_o     (s_mark)
    );

    sq_commit #(.DEPTH(DEPTH), .AW(AW), .LINE_BYTES(LINE_BYTES)) u_commit (
        .st_i   (st),
        .addr_i (s_addr),
        .data_i (s_data),
        .owned_i(s_owned),
        .head_i (head_q[PW-1:0]),
        .used_i (used),
        .valid_o(commit_valid_o),
        .line_o (commit_line_o),
        .be_o   (commit_be_o),
        .data_o (commit_data_o),
        .take_o (take),
        .drain_o(s_drain)
    );

    sq_fwd #(.DEPTH(DEPTH), .AW(AW), .LBW(LBW)) u_fwd (
        .st_i     (st),
        .addr_i   (s_addr),
        .data_i   (s_data),
        .head_i   (head_q),
        .ld_addr_i(ld_addr_i),
        .ld_wide_i(ld_wide_i),
        .ld_tail_i(ld_tail_i),
        .hit_o    (ld_hit_o),
        .wait_o   (ld_wait_o),
        .data_o   (ld_data_o)
    );

    // Slots are only freed at the head, so a non-empty queue has a live head slot.
    assert_head_not_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !drained_o |-> st[head_q[PW-1:0]] != SLOT_FREE);

    assert_commit_retired_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid_o |-> st[head_q[PW-1:0]] == SLOT_DONE);

    assert_commit_owned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid_o |-> s_owned[head_q[PW-1:0]]);

    // Input rule: retirement follows execution, in order.
    assert_retire_executed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        retire_i |-> st[ret_q[PW-1:0]] == SLOT_SPEC);

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        used <= (PW+1)'(DEPTH));
endmodule

// File: tb/test_store_queue.sv
`timescale 1ns/1ps
module test_store_queue;
    localparam int DEPTH = 8;
    localparam int AW    = 12;
    localparam int LB    = 4;
    localparam int PW    = 3;
    localparam int LW    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_i = 0, exec_i = 0, retire_i = 0, flush_i = 0, gnt_i = 0, ld_wide_i = 0;
    logic [PW-1:0] exec_idx_i = '0;
    logic [AW-1:0] exec_addr_i = '0, ld_addr_i = '0;
    logic [7:0]    exec_data_i = '0;
    logic [LW-1:0] gnt_line_i = '0;
    logic [PW:0]   ld_tail_i = '0;
    logic [PW:0]   alloc_ptr_o;
    logic          full_o, drained_o, rfo_valid_o, commit_valid_o, ld_hit_o, ld_wait_o;
    logic [LW-1:0] rfo_line_o, commit_line_o;
    logic [LB-1:0] commit_be_o;
    logic [8*LB-1:0] commit_data_o;
    logic [7:0]    ld_data_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    store_queue #(.DEPTH(DEPTH), .AW(AW), .LINE_BYTES(LB)) i_store_queue (.*);

    typedef struct packed {
        logic [AW-1:0] a;
        logic          wide;
        logic [PW:0]   tail;
        logic          hit;
        logic          wt;
        logic [7:0]    d;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{12'h010, 1'b0, 4'd3, 1'b1, 1'b0, 8'hC3},
        '{12'h010, 1'b0, 4'd2, 1'b1, 1'b0, 8'hA1},
        '{12'h011, 1'b0, 4'd3, 1'b1, 1'b0, 8'hB2},
        '{12'h012, 1'b0, 4'd3, 1'b0, 1'b0, 8'h00},
        '{12'h010, 1'b0, 4'd1, 1'b1, 1'b0, 8'hA1},
        '{12'h010, 1'b0, 4'd0, 1'b0, 1'b0, 8'h00},
        '{12'h010, 1'b1, 4'd3, 1'b0, 1'b1, 8'h00},
        '{12'h020, 1'b1, 4'd3, 1'b0, 1'b0, 8'h00},
        '{12'h013, 1'b0, 4'd4, 1'b0, 1'b1, 8'h00},
        '{12'h010, 1'b0, 4'd4, 1'b0, 1'b1, 8'h00}
    };

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_exec(input logic [PW-1:0] idx, input logic [AW-1:0] a, input logic [7:0] d);
        exec_i = 1; exec_idx_i = idx; exec_addr_i = a; exec_data_i = d;
        cyc();
        exec_i = 0;
    endtask

    task automatic do_grant(input logic [LW-1:0] line);
        gnt_i = 1; gnt_line_i = line;
        cyc();
        gnt_i = 0;
    endtask

    task automatic do_retire(input int n);
        for (int i = 0; i < n; i++) begin
            retire_i = 1;
            cyc();
        end
        retire_i = 0;
    endtask

    task automatic do_alloc(input int n);
        for (int i = 0; i < n; i++) begin
            alloc_i = 1;
            cyc();
        end
        alloc_i = 0;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R10 reset state
        chk("R10 drained", 32'(drained_o), 32'd1);
        chk("R10 full", 32'(full_o), 32'd0);
        chk("R10 ptr", 32'(alloc_ptr_o), 32'd0);
        chk("R10 commit", 32'(commit_valid_o), 32'd0);
        chk("R10 rfo", 32'(rfo_valid_o), 32'd0);

        do_alloc(4);
        chk("R9 ptr after 4 allocs", 32'(alloc_ptr_o), 32'd4);
        do_exec(3'd0, 12'h010, 8'hA1);
        // R5 request raised for a freshly filled slot
        chk("R5 rfo valid", 32'(rfo_valid_o), 32'd1);
        chk("R5 rfo line", 32'(rfo_line_o), 32'h4);
        do_exec(3'd1, 12'h011, 8'hB2);
        do_exec(3'd2, 12'h010, 8'hC3);
        repeat (3) cyc();

        // R6 / R7 forwarding table, slot 3 has no address yet
        foreach (VECS[v]) begin
            ld_addr_i = VECS[v].a;
            ld_wide_i = VECS[v].wide;
            ld_tail_i = VECS[v].tail;
            #1;
            chk($sformatf("R6_R7 load vector %0d", v),
                {22'd0, ld_hit_o, ld_wait_o, ld_data_o},
                {22'd0, VECS[v].hit, VECS[v].wt, VECS[v].d});
        end
        ld_wide_i = 0;
        ld_tail_i = '0;

        do_exec(3'd3, 12'h030, 8'hD4);
        // R5 younger slot requests ownership while head still uncommitted
        chk("R5 early rfo valid", 32'(rfo_valid_o), 32'd1);
        chk("R5 early rfo line", 32'(rfo_line_o), 32'hC);
        chk("R5 head still held", 32'(commit_valid_o), 32'd0);
        cyc();

        do_retire(3);
        chk("R3 retired but not owned", 32'(commit_valid_o), 32'd0);
        do_grant(10'h4);
        // R4 merged write of three slots
        chk("R4 merge valid", 32'(commit_valid_o), 32'd1);
        chk("R4 merge line", 32'(commit_line_o), 32'h4);
        chk("R4 merge be", 32'(commit_be_o), 32'h3);
        chk("R4 merge data", commit_data_o, 32'h0000B2C3);
        cyc();
        chk("R2 next head not retired", 32'(commit_valid_o), 32'd0);
        do_grant(10'hC);
        chk("R2 owned but not retired", 32'(commit_valid_o), 32'd0);
        do_retire(1);
        chk("R2 commit after retire", 32'(commit_valid_o), 32'd1);
        chk("R2 commit be", 32'(commit_be_o), 32'h1);
        chk("R2 commit data", commit_data_o, 32'h000000D4);
        cyc();
        chk("R9 drained after commits", 32'(drained_o), 32'd1);

        // R1 order: younger line granted first
        do_alloc(2);
        do_exec(3'd4, 12'h044, 8'h11);
        do_exec(3'd5, 12'h087, 8'h22);
        repeat (3) cyc();
        do_retire(2);
        do_grant(10'h21);
        chk("R1 younger owned, older held", 32'(commit_valid_o), 32'd0);
        do_grant(10'h11);
        chk("R1 older line first", 32'(commit_line_o), 32'h11);
        chk("R1 older data", commit_data_o, 32'h00000011);
        chk("R1 older valid", 32'(commit_valid_o), 32'd1);
        cyc();
        chk("R1 younger line next", 32'(commit_line_o), 32'h21);
        chk("R1 younger be", 32'(commit_be_o), 32'h8);
        chk("R1 younger data", commit_data_o, 32'h22000000);
        cyc();
        chk("R1 drained", 32'(drained_o), 32'd1);

        // R8 flush keeps the retired slot only
        do_alloc(3);
        chk("R8 ptr wraps", 32'(alloc_ptr_o), 32'd9);
        do_exec(3'd6, 12'h100, 8'h55);
        do_exec(3'd7, 12'h104, 8'h66);
        do_exec(3'd0, 12'h108, 8'h77);
        do_retire(1);
        flush_i = 1;
        cyc();
        flush_i = 0;
        chk("R8 tail after flush", 32'(alloc_ptr_o), 32'd7);
        chk("R8 retired slot kept", 32'(drained_o), 32'd0);
        repeat (4) cyc();
        do_grant(10'h40);
        chk("R8 retired slot drains", 32'(commit_valid_o), 32'd1);
        chk("R8 drained data", commit_data_o, 32'h00000055);
        cyc();
        chk("R8 flushed slots gone", 32'(drained_o), 32'd1);

        // R9 full and ignored allocation
        do_alloc(DEPTH + 1);
        chk("R9 full", 32'(full_o), 32'd1);
        chk("R9 alloc ignored when full", 32'(alloc_ptr_o), 32'd15);
        flush_i = 1;
        cyc();
        flush_i = 0;
        chk("R9 not full after flush", 32'(full_o), 32'd0);
        chk("R9 drained after flush", 32'(drained_o), 32'd1);
        chk("R8 tail back", 32'(alloc_ptr_o), 32'd7);

        summary();
        $finish;
    end
endmodule